// File: doc/BRIEF.md
# ADC Power-Up Sequencer

This block runs on the host side and takes a multichannel delta-sigma converter from cold power to trustworthy samples. It waits for a supply-good indication and then turns on the converter's master clock after a programmable delay. A fixed number of master-clock periods later it lifts the converter out of reset. From that moment it tracks two separate windows. The first is a filter-settling count. The second is a longer window that lets the reference and internal nodes stabilise.

The converter's active-low sample-ready line passes through a synchronizer before its falling edges are used. The first qualifying falling edge after the filter window produces a one-cycle "filter settled" pulse. The next qualifying edge after the stabilisation window produces a one-cycle "first valid" pulse and raises a sticky valid level.

A register-write-busy input from the host's configuration logic clears and restarts the filter window. Losing supply-good at any point sends the sequencer back to idle with every drive line low. All delays are parameters given in system-clock cycles.

Top module: `adc_pwrup_seq`

## Requirements
- R1: After system reset, and while `pwr_good_i` is low, `mclk_en_o`, `conv_reset_n_o`, `data_valid_o`, `settled_pulse_o` and `valid_pulse_o` are all low, `state_o` is 0, and falling edges on `sample_rdy_ni` or pulses on `reg_busy_i` produce no pulse.
- R2: `mclk_en_o` rises exactly CLK_DLY_CYC+1 cycles after the first clock edge that samples `pwr_good_i` high.
- R3: `conv_reset_n_o` rises exactly RST_MCLK*SYS_PER_MCLK+1 cycles after `mclk_en_o` rises and is never high while `mclk_en_o` is low.
- R4: A falling edge of `sample_rdy_ni` is first sampled low at edge E. It is judged in the cycle that follows edge E+1. If it qualifies, the pulse is high for the one cycle that follows edge E+2. In the filter stage, the edge qualifies for `settled_pulse_o` only if at least SETTLE_MCLK*SYS_PER_MCLK cycles separate the start of the filter window from the judging cycle. The filter window starts at the reset release, or at the last cycle `reg_busy_i` is sampled high. Earlier edges are dropped.
- R5: After the settled pulse, the next edge whose judging cycle lies at least STABLE_CYC cycles after the reset release raises `valid_pulse_o` for one cycle, with the same timing as R4. `data_valid_o` then stays high.
- R6: If `reg_busy_i` is sampled high in the filter or stabilisation stage, the sequencer is in the filter stage on the next cycle with the filter window cleared. A new settled pulse is then needed. Edges judged while busy is high never qualify. The stabilisation window is not restarted.
- R7: Once valid, `reg_busy_i` and further falling edges have no effect: `data_valid_o` stays high, `state_o` stays 5, and no pulse occurs.
- R8: If `pwr_good_i` is sampled low in any state, every output listed in R1 is low and `state_o` is 0 from the next cycle on.
- R9: `state_o` encodes 0 idle, 1 clock delay, 2 reset delay, 3 filter settling, 4 stabilising, 5 valid.
- R10: Each pulse output is high for a single cycle, and each settling pass yields at most one settled pulse and one valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| pwr_good_i | input | 1 | Supplies are within range (synchronous to clk_i) |
| sample_rdy_ni | input | 1 | Converter sample-ready strobe, active low, asynchronous |
| reg_busy_i | input | 1 | Converter register write in progress |
| mclk_en_o | output | 1 | Enables the converter master clock |
| conv_reset_n_o | output | 1 | Converter reset, active low |
| settled_pulse_o | output | 1 | One-cycle pulse on the first filter-settled sample |
| valid_pulse_o | output | 1 | One-cycle pulse on the first valid sample |
| data_valid_o | output | 1 | Level, high once valid data has been reached |
| state_o | output | 3 | Sequencer state code (R9) |

## Verification
The assertions take two things for granted. First, `pwr_good_i` and `reg_busy_i` are already synchronous to `clk_i`. Second, every filter window is at least one cycle long, so clearing the window always removes its done flag. The stimulus drives all inputs at the falling clock edge. Each sample-ready strobe stays low for three cycles and then high for three, so the two-flop synchronizer sees every edge cleanly. Busy pulses are never placed over a strobe's judging cycle, so the predicted outcome of each edge never depends on a busy/edge collision.

// File: rtl/adc_pwrup_pkg.sv
package adc_pwrup_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE     = 3'd0,
      SEQ_CLK_WAIT = 3'd1,
      SEQ_RST_WAIT = 3'd2,
      SEQ_SETTLE   = 3'd3,
      SEQ_STABLE   = 3'd4,
      SEQ_VALID    = 3'd5
   } seq_state_e;

endpackage

// File: rtl/pwrup_span_cnt.sv
module pwrup_span_cnt #(
   parameter int LIMIT = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   output logic done_o
);
   localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("pwrup_span_cnt: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (clr_i)           cnt_q <= '0;
      else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == LIM);

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIM); // R4

   AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !done_o); // R6

endmodule

// File: rtl/pwrup_edge_sync.sv
module pwrup_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_ni,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwrup_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[g] <= 1'b1;
            else         chain_q[g] <= async_ni;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[g] <= 1'b1;
            else         chain_q[g] <= chain_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b1;
      else         last_q <= chain_q[STAGES-1];
   end

   assign fall_o = last_q & ~chain_q[STAGES-1];

   AST_FALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !fall_o); // R10

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
   import adc_pwrup_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pwr_good_i,
   input  logic       busy_i,
   input  logic       fall_i,
   input  logic       clk_done_i,
   input  logic       rst_done_i,
   input  logic       filt_done_i,
   input  logic       stab_done_i,
   output logic       clk_clr_o,
   output logic       rst_clr_o,
   output logic       filt_clr_o,
   output logic       stab_clr_o,
   output logic       mclk_en_o,
   output logic       conv_reset_n_o,
   output logic       settled_pulse_o,
   output logic       valid_pulse_o,
   output logic       data_valid_o,
   output logic [2:0] state_o
);
   seq_state_e state_q, state_d;
   logic       settled_q, settled_d;
   logic       valid_q, valid_d;

   always_comb begin
      state_d   = state_q;
      settled_d = 1'b0;
      valid_d   = 1'b0;
      if (!pwr_good_i) begin
         state_d = SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE:     state_d = SEQ_CLK_WAIT;
            SEQ_CLK_WAIT: if (clk_done_i) state_d = SEQ_RST_WAIT;
            SEQ_RST_WAIT: if (rst_done_i) state_d = SEQ_SETTLE;
            SEQ_SETTLE: begin
               if (!busy_i && fall_i && filt_done_i) begin
                  state_d   = SEQ_STABLE;
                  settled_d = 1'b1;
               end
            end
            SEQ_STABLE: begin
               if (busy_i) begin
                  state_d = SEQ_SETTLE;
               end else if (fall_i && stab_done_i) begin
                  state_d = SEQ_VALID;
                  valid_d = 1'b1;
               end
            end
            SEQ_VALID:    state_d = SEQ_VALID;
            default:      state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= SEQ_IDLE;
         settled_q <= 1'b0;
         valid_q   <= 1'b0;
      end else begin
         state_q   <= state_d;
         settled_q <= settled_d;
         valid_q   <= valid_d;
      end
   end

   assign clk_clr_o  = (state_q != SEQ_CLK_WAIT);
   assign rst_clr_o  = (state_q != SEQ_RST_WAIT);
   assign filt_clr_o = (state_q != SEQ_SETTLE) || busy_i;
   assign stab_clr_o = (state_q == SEQ_IDLE) || (state_q == SEQ_CLK_WAIT)
                       || (state_q == SEQ_RST_WAIT);

   assign mclk_en_o       = (state_q != SEQ_IDLE) && (state_q != SEQ_CLK_WAIT);
   assign conv_reset_n_o  = mclk_en_o && (state_q != SEQ_RST_WAIT);
   assign data_valid_o    = (state_q == SEQ_VALID);
   assign settled_pulse_o = settled_q;
   assign valid_pulse_o   = valid_q;
   assign state_o         = state_q;

   AST_QUIET_WHEN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_i |=> (!mclk_en_o && !conv_reset_n_o && !data_valid_o
                       && !settled_pulse_o && !valid_pulse_o)); // R8

   AST_CLK_AFTER_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mclk_en_o) |-> $past(clk_done_i)); // R2

   AST_RST_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(conv_reset_n_o) |-> ($past(rst_done_i) && $past(mclk_en_o))); // R3

   AST_SETTLED_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      settled_pulse_o |-> ($past(filt_done_i) && $past(fall_i))); // R4

   AST_VALID_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_pulse_o |-> ($past(stab_done_i) && $past(fall_i) && data_valid_o)); // R5

   AST_BUSY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_good_i && busy_i && (state_q == SEQ_SETTLE || state_q == SEQ_STABLE))
      |=> (state_q == SEQ_SETTLE && !filt_done_i)); // R6

   AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_good_i && data_valid_o) |=> (data_valid_o && !settled_pulse_o
                                         && !valid_pulse_o)); // R7

   AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled_pulse_o || valid_pulse_o) |=> (!settled_pulse_o && !valid_pulse_o)); // R10

endmodule

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq #(
   parameter int SYS_PER_MCLK = 25,
   parameter int CLK_DLY_CYC  = 10000,
   parameter int RST_MCLK     = 2,
   parameter int SETTLE_MCLK  = 2312,
   parameter int STABLE_CYC   = 440000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pwr_good_i,
   input  logic       sample_rdy_ni,
   input  logic       reg_busy_i,
   output logic       mclk_en_o,
   output logic       conv_reset_n_o,
   output logic       settled_pulse_o,
   output logic       valid_pulse_o,
   output logic       data_valid_o,
   output logic [2:0] state_o
);
   localparam int RST_CYC    = RST_MCLK * SYS_PER_MCLK;
   localparam int SETTLE_CYC = SETTLE_MCLK * SYS_PER_MCLK;

   if (SYS_PER_MCLK < 1) begin : g_bad_ratio
      $error("adc_pwrup_seq: SYS_PER_MCLK must be at least 1");
   end
   if (STABLE_CYC < SETTLE_CYC) begin : g_bad_stable
      $error("adc_pwrup_seq: STABLE_CYC must not be shorter than the filter window");
   end

   logic fall;
   logic clk_clr, rst_clr, filt_clr, stab_clr;
   logic clk_done, rst_done, filt_done, stab_done;

   pwrup_edge_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .async_ni (sample_rdy_ni),
      .fall_o   (fall)
   );

   pwrup_span_cnt #(.LIMIT(CLK_DLY_CYC)) u_clk_dly (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clk_clr),
      .en_i  (pwr_good_i), .done_o (clk_done)
   );

   pwrup_span_cnt #(.LIMIT(RST_CYC)) u_rst_dly (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (rst_clr),
      .en_i  (pwr_good_i), .done_o (rst_done)
   );

   pwrup_span_cnt #(.LIMIT(SETTLE_CYC)) u_filt_win (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (filt_clr),
      .en_i  (pwr_good_i), .done_o (filt_done)
   );

   pwrup_span_cnt #(.LIMIT(STABLE_CYC)) u_stab_win (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (stab_clr),
      .en_i  (pwr_good_i), .done_o (stab_done)
   );

   pwrup_fsm u_fsm (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .pwr_good_i      (pwr_good_i),
      .busy_i          (reg_busy_i),
      .fall_i          (fall),
      .clk_done_i      (clk_done),
      .rst_done_i      (rst_done),
      .filt_done_i     (filt_done),
      .stab_done_i     (stab_done),
      .clk_clr_o       (clk_clr),
      .rst_clr_o       (rst_clr),
      .filt_clr_o      (filt_clr),
      .stab_clr_o      (stab_clr),
      .mclk_en_o       (mclk_en_o),
      .conv_reset_n_o  (conv_reset_n_o),
      .settled_pulse_o (settled_pulse_o),
      .valid_pulse_o   (valid_pulse_o),
      .data_valid_o    (data_valid_o),
      .state_o         (state_o)
   );

endmodule

// File: tb/adc_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module adc_pwrup_seq_tb_top;
   localparam int P_MCLK = 2;
   localparam int D      = 20;
   localparam int RM     = 2;
   localparam int SM     = 10;
   localparam int T      = 150;
   localparam int R      = RM * P_MCLK;
   localparam int F      = SM * P_MCLK;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0;
   logic rdy_n = 1'b1;
   logic busy = 1'b0;
   logic mclk_en, conv_rst_n, settled_p, valid_p, data_valid;
   logic [2:0] st;

   always #2.5 clk = ~clk;

   adc_pwrup_seq #(
      .SYS_PER_MCLK(P_MCLK), .CLK_DLY_CYC(D), .RST_MCLK(RM),
      .SETTLE_MCLK(SM), .STABLE_CYC(T), .SYNC_STAGES(2)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good),
      .sample_rdy_ni(rdy_n), .reg_busy_i(busy),
      .mclk_en_o(mclk_en), .conv_reset_n_o(conv_rst_n),
      .settled_pulse_o(settled_p), .valid_pulse_o(valid_p),
      .data_valid_o(data_valid), .state_o(st)
   );

   int cyc = 0;
   int total = 0;
   int fails = 0;
   int exp_kind[$];
   int exp_cyc[$];
   int m_phase = 0;
   int s_cyc = 0;
   int fs = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a pulse appears
   always @(negedge clk) begin
      if (rst_n) begin
         if (settled_p) begin
            total++;
            if (exp_kind.size() == 0) begin
               fails++;
               $display("FAIL R10 unexpected settled pulse: got cycle %0d expected none", cyc);
            end else begin
               int k, c;
               k = exp_kind.pop_front();
               c = exp_cyc.pop_front();
               if (k != 1 || c != cyc) begin
                  fails++;
                  $display("FAIL R4 settled pulse: got kind 1 at %0d expected kind %0d at %0d", cyc, k, c);
               end
            end
         end
         if (valid_p) begin
            total++;
            if (exp_kind.size() == 0) begin
               fails++;
               $display("FAIL R10 unexpected valid pulse: got cycle %0d expected none", cyc);
            end else begin
               int k, c;
               k = exp_kind.pop_front();
               c = exp_cyc.pop_front();
               if (k != 2 || c != cyc) begin
                  fails++;
                  $display("FAIL R5 valid pulse: got kind 2 at %0d expected kind %0d at %0d", cyc, k, c);
               end
            end
         end
      end
   end

   task automatic wait_until(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   // driver: one sample-ready strobe, predicted from R4/R5/R7
   task automatic rdy_fall();
      int judge;
      judge = cyc + 2;
      if (m_phase == 1 && judge >= fs + F) begin
         exp_kind.push_back(1); exp_cyc.push_back(cyc + 3); m_phase = 2;
      end else if (m_phase == 2 && judge >= s_cyc + T) begin
         exp_kind.push_back(2); exp_cyc.push_back(cyc + 3); m_phase = 3;
      end
      rdy_n = 1'b0;
      repeat (3) @(negedge clk);
      rdy_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic busy_pulse(input int len);
      int was;
      was = m_phase;
      busy = 1'b1;
      @(negedge clk);
      if (was == 2) chk(st == 3'd3, "R6", "state after busy in stabilising", st, 3);
      repeat (len - 1) @(negedge clk);
      busy = 1'b0;
      if (was == 1 || was == 2) begin
         m_phase = 1;
         fs = cyc;
      end
   endtask

   task automatic power_up();
      int c0, mc, rc;
      c0 = cyc; mc = -1; rc = -1;
      pwr_good = 1'b1;
      for (int i = 0; i < D + R + 20 && rc < 0; i++) begin
         @(negedge clk);
         if (i == 0) chk(st == 3'd1, "R9", "state in clock delay", st, 1);
         if (conv_rst_n && !mclk_en)
            chk(1'b0, "R3", "reset released without clock", 1, 0);
         if (mclk_en && mc < 0) mc = cyc;
         if (conv_rst_n && rc < 0) rc = cyc;
      end
      chk(mc == c0 + D + 2, "R2", "mclk enable cycle", mc, c0 + D + 2);
      chk(rc == mc + R + 1, "R3", "reset release cycle", rc, mc + R + 1);
      chk(st == 3'd3, "R9", "state at reset release", st, 3);
      s_cyc = rc; fs = rc; m_phase = 1;
   endtask

   task automatic power_down(input string req);
      pwr_good = 1'b0;
      @(negedge clk);
      chk(!mclk_en && !conv_rst_n && !data_valid && !settled_p && !valid_p,
          req, "outputs after supply loss", {mclk_en, conv_rst_n, data_valid}, 0);
      chk(st == 3'd0, req, "state after supply loss", st, 0);
      m_phase = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mclk_en && !conv_rst_n && !data_valid && !settled_p && !valid_p,
          "R1", "outputs after reset", {mclk_en, conv_rst_n, data_valid}, 0);
      chk(st == 3'd0, "R1", "state after reset", st, 0);

      // R1: stimulus while supply is down has no effect
      rdy_fall();
      busy_pulse(3);
      repeat (3) @(negedge clk);
      chk(!mclk_en && !conv_rst_n && !data_valid && st == 3'd0, "R1",
          "outputs idle after stimulus", st, 0);

      // first run: plain sequence
      power_up();
      wait_until(s_cyc + 2);
      rdy_fall();                         // R4 too early
      wait_until(fs + F - 3);
      rdy_fall();                         // R4 one cycle short
      rdy_fall();                         // R4 qualifies
      chk(st == 3'd4, "R9", "state stabilising", st, 4);
      rdy_fall();                         // R5 too early
      wait_until(s_cyc + T - 3);
      rdy_fall();                         // R5 one cycle short
      rdy_fall();                         // R5 qualifies
      chk(data_valid === 1'b1, "R5", "valid level", data_valid, 1);
      chk(st == 3'd5, "R9", "state valid", st, 5);

      // R7: ignored once valid
      busy_pulse(4);
      rdy_fall();
      chk(data_valid === 1'b1 && st == 3'd5, "R7", "valid held", st, 5);

      power_down("R8");

      // drop while settling
      power_up();
      repeat (5) @(negedge clk);
      power_down("R8");
      repeat (3) @(negedge clk);

      // second run: register writes
      power_up();
      wait_until(s_cyc + 5);
      busy_pulse(6);                      // R6 restart in filter stage
      wait_until(s_cyc + F);
      rdy_fall();                         // would qualify without busy
      wait_until(fs + F - 2);
      rdy_fall();                         // R4 exact boundary
      chk(st == 3'd4, "R6", "state after settle", st, 4);
      busy_pulse(3);                      // R6 back to filter stage
      rdy_fall();                         // no pulse, window restarted
      wait_until(fs + F - 2);
      rdy_fall();                         // settled again
      wait_until(s_cyc + T - 2);
      rdy_fall();                         // R5 exact boundary
      chk(data_valid === 1'b1, "R5", "valid after restart", data_valid, 1);

      repeat (5) @(negedge clk);
      chk(exp_kind.size() == 0, "R10", "pending expected pulses", exp_kind.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule